// File: doc/BRIEF.md
# Serial ADC Conversion Frame Controller

This block sits on the host side of a serial successive-approximation converter whose conversion runs on the serial clock the host supplies. Each frame starts when the active-low chip select falls. That edge captures the analog input and starts the conversion. The controller then produces a divided serial clock with a fixed count of cycles and shifts in the returning bits. At the end of the frame it presents a 12-bit result with a one-cycle strobe.

The controller then holds chip select high long enough for two things. The converter's quiet time must pass. The converter's track/hold must also get its acquisition time, counted from the rising serial-clock edge on which it went back to tracking. The hold-off is worked out in system-clock cycles from the latched divider and the system-clock period. As a result, continuous conversion runs at the fastest rate the timing rules permit for each divider setting.

A host either pulses a start request for one frame or holds the continuous request high. It chooses the serial clock rate with the half-period input.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted, and at once when it is applied mid-frame, chip select is high, serial clock is high, the strobe is low and the result reads 0. An aborted frame produces no strobe.
- R2: A request seen in idle drives chip select low on the next clock edge. The first serial-clock falling edge follows ceil(10 ns / clock period) cycles later, which is 2 cycles at a 5 ns clock.
- R3: Every frame has exactly 16 serial-clock cycles, each starting with a falling edge. The end of the last high phase coincides with the chip-select rise.
- R4: Each phase of the serial clock in R3 lasts H system cycles, where H = max(half-period input, ceil(25 ns / clock period)), so 5 at the defaults. H is latched when chip select falls, and later changes to the input do not affect the running frame.
- R5: The serial clock is high whenever chip select is high, and it changes only while chip select is low.
- R6: The data input is sampled at each serial-clock rising edge and shifted in MSB first. The result equals the last 12 of the 16 bits of the frame whose chip-select fall took the sample. The first 4 bits are ignored.
- R7: The strobe is high for exactly one cycle, in the cycle where chip select has just risen. The result stays unchanged until the next strobe.
- R8: Chip select stays high for at least G cycles after each frame, G = max(ceil(100 ns / T), ceil(300 ns / T) - 7*H, 1), where T is the clock period. The next chip-select fall also comes at least 300 ns after the 13th serial-clock rising edge.
- R9: With the continuous request held high, chip select falls again exactly G cycles after it rose.
- R10: A start pulse in idle runs one frame. A start received while a frame or its hold-off is running is remembered once, and that frame begins exactly G cycles after chip select rises. Several such pulses still give one extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any frame |
| start_i | input | 1 | Single-frame request pulse |
| cont_i | input | 1 | Continuous conversion request (level) |
| half_div_i | input | DIV_W | Serial-clock half period in system cycles |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | DATA_W | Last converted result |
| valid_o | output | 1 | One-cycle strobe with a new result |

## Verification
A corrupted edge counter or half-period counter shows up in the same frame. The bench times every serial-clock edge against H and counts 16 cycles at the chip-select rise, so the error is seen within one half period. A bad shift register or an off-by-one sampling edge gives a wrong result at that frame's strobe. A wrong hold-off count or a lost pending request shows up at the next chip-select fall, because the gap is measured to the exact cycle in continuous and held-request runs and bounded from below everywhere else.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic [1:0] {
      AFC_IDLE,
      AFC_SETUP,
      AFC_SHIFT,
      AFC_GAP
   } afc_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/afc_sclk_gen.sv
module afc_sclk_gen #(
   parameter int DIV_W      = 8,
   parameter int FRAME_CLKS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             sclk_o,
   output logic             sample_o,
   output logic             done_o
);
   localparam int EDGE_W = $clog2(2 * FRAME_CLKS + 1);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * FRAME_CLKS);

   logic [DIV_W-1:0]  cnt_q;
   logic [EDGE_W-1:0] edge_q;
   logic              run_q;
   logic              sclk_q;
   logic              tick;

   assign tick     = run_q && (cnt_q == '0);
   assign done_o   = tick && (edge_q == LAST_EDGE);
   assign sample_o = tick && !sclk_q;
   assign sclk_o   = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         run_q  <= 1'b0;
         cnt_q  <= '0;
         edge_q <= '0;
      end else if (launch_i) begin
         sclk_q <= 1'b0;
         run_q  <= 1'b1;
         cnt_q  <= half_i - 1'b1;
         edge_q <= EDGE_W'(1);
      end else if (run_q) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (edge_q == LAST_EDGE) begin
            run_q <= 1'b0;
         end else begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            cnt_q  <= half_i - 1'b1;
         end
      end
   end
endmodule

// File: rtl/afc_rx_shift.sv
module afc_rx_shift #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], bit_i};
   end

   assign data_o = sh_q;
endmodule

// File: rtl/afc_gap_calc.sv
module afc_gap_calc #(
   parameter int DIV_W       = 8,
   parameter int GAP_W       = 6,
   parameter int QUIET_CYC   = 20,
   parameter int ACQ_CYC     = 60,
   parameter int TAIL_HALVES = 7,
   parameter int MIN_HALF    = 5
) (
   input  logic [DIV_W-1:0] half_i,
   output logic [GAP_W-1:0] gap_o
);
   localparam int FLOOR_CYC = (QUIET_CYC > 1) ? QUIET_CYC : 1;

   generate
      if (ACQ_CYC <= TAIL_HALVES * MIN_HALF + FLOOR_CYC) begin : g_quiet_only
         assign gap_o = GAP_W'(FLOOR_CYC);
      end else begin : g_acq_aware
         int acq_left;
         always_comb begin
            acq_left = ACQ_CYC - TAIL_HALVES * int'(half_i);
            if (acq_left > FLOOR_CYC) gap_o = GAP_W'(acq_left);
            else                      gap_o = GAP_W'(FLOOR_CYC);
         end
      end
   endgenerate
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
   parameter int CLK_NS      = 5,
   parameter int SCLK_MIN_NS = 50,
   parameter int SETUP_NS    = 10,
   parameter int QUIET_NS    = 100,
   parameter int ACQ_NS      = 300,
   parameter int DATA_W      = 12,
   parameter int FRAME_CLKS  = 16,
   parameter int TRACK_RISE  = 13,
   parameter int DIV_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cont_i,
   input  logic [DIV_W-1:0]  half_div_i,
   input  logic              sdata_i,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic [DATA_W-1:0] result_o,
   output logic              valid_o
);
   import afc_pkg::*;

   localparam int MIN_HALF    = ceil_div(SCLK_MIN_NS, 2 * CLK_NS);
   localparam int SETUP_CYC   = max_int(1, ceil_div(SETUP_NS, CLK_NS));
   localparam int QUIET_CYC   = ceil_div(QUIET_NS, CLK_NS);
   localparam int ACQ_CYC     = ceil_div(ACQ_NS, CLK_NS);
   localparam int TAIL_HALVES = 2 * (FRAME_CLKS - TRACK_RISE) + 1;
   localparam int GAP_MAX     = max_int(max_int(QUIET_CYC, ACQ_CYC), 1);
   localparam int GAP_W       = $clog2(GAP_MAX + 1);
   localparam int SET_W       = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

   generate
      if (DATA_W < 2 || DATA_W > FRAME_CLKS) begin : g_bad_data_w
         $error("adc_frame_ctrl: DATA_W must lie in 2..FRAME_CLKS");
      end
      if (TRACK_RISE < 1 || TRACK_RISE > FRAME_CLKS) begin : g_bad_track
         $error("adc_frame_ctrl: TRACK_RISE must lie in 1..FRAME_CLKS");
      end
      if (MIN_HALF >= (1 << DIV_W)) begin : g_bad_div_w
         $error("adc_frame_ctrl: DIV_W too narrow for the minimum half period");
      end
   endgenerate

   afc_state_e        state_q;
   logic              cs_q;
   logic              valid_q;
   logic [DATA_W-1:0] result_q;
   logic              pend_q;
   logic [SET_W-1:0]  setup_q;
   logic [GAP_W-1:0]  gap_q;
   logic [DIV_W-1:0]  half_q;
   logic [DIV_W-1:0]  eff_half;
   logic [GAP_W-1:0]  gap_len;
   logic [DATA_W-1:0] rx_word;
   logic              go;
   logic              begin_now;
   logic              launch;
   logic              sample;
   logic              done;

   generate
      if (MIN_HALF > 1) begin : g_clamp
         assign eff_half = (half_div_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div_i;
      end else begin : g_nonzero
         assign eff_half = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
      end
   endgenerate

   assign go        = start_i || pend_q || cont_i;
   assign begin_now = go && ((state_q == AFC_IDLE) ||
                             ((state_q == AFC_GAP) && (gap_q == '0)));
   assign launch    = (state_q == AFC_SETUP) && (setup_q == '0);

   afc_sclk_gen #(
      .DIV_W      (DIV_W),
      .FRAME_CLKS (FRAME_CLKS)
   ) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .half_i   (half_q),
      .sclk_o   (sclk_o),
      .sample_o (sample),
      .done_o   (done)
   );

   afc_rx_shift #(
      .DATA_W (DATA_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (sample),
      .bit_i   (sdata_i),
      .data_o  (rx_word)
   );

   afc_gap_calc #(
      .DIV_W       (DIV_W),
      .GAP_W       (GAP_W),
      .QUIET_CYC   (QUIET_CYC),
      .ACQ_CYC     (ACQ_CYC),
      .TAIL_HALVES (TAIL_HALVES),
      .MIN_HALF    (MIN_HALF)
   ) u_gap (
      .half_i (half_q),
      .gap_o  (gap_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= AFC_IDLE;
         cs_q     <= 1'b1;
         valid_q  <= 1'b0;
         result_q <= '0;
         pend_q   <= 1'b0;
         setup_q  <= '0;
         gap_q    <= '0;
         half_q   <= DIV_W'(MIN_HALF);
      end else begin
         valid_q <= 1'b0;
         if (begin_now) begin
            cs_q    <= 1'b0;
            state_q <= AFC_SETUP;
            setup_q <= SET_W'(SETUP_CYC - 1);
            half_q  <= eff_half;
            pend_q  <= 1'b0;
         end else begin
            if (start_i && (state_q != AFC_IDLE)) pend_q <= 1'b1;
            case (state_q)
               AFC_SETUP: begin
                  if (setup_q != '0) setup_q <= setup_q - 1'b1;
                  else               state_q <= AFC_SHIFT;
               end
               AFC_SHIFT: begin
                  if (done) begin
                     cs_q     <= 1'b1;
                     valid_q  <= 1'b1;
                     result_q <= rx_word;
                     gap_q    <= gap_len - 1'b1;
                     state_q  <= AFC_GAP;
                  end
               end
               AFC_GAP: begin
                  if (gap_q != '0) gap_q   <= gap_q - 1'b1;
                  else             state_q <= AFC_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign cs_n_o   = cs_q;
   assign valid_o  = valid_q;
   assign result_o = result_q;
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
   parameter int CLK_NS      = 5,
   parameter int SCLK_MIN_NS = 50,
   parameter int SETUP_NS    = 10,
   parameter int QUIET_NS    = 100
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n_o,
   input logic sclk_o,
   input logic valid_o
);
   import afc_pkg::*;

   localparam int MIN_HALF  = ceil_div(SCLK_MIN_NS, 2 * CLK_NS);
   localparam int SETUP_CYC = max_int(1, ceil_div(SETUP_NS, CLK_NS));
   localparam int QUIET_CYC = ceil_div(QUIET_NS, CLK_NS);
   localparam int CNT_W     = 16;
   localparam logic [CNT_W-1:0] SAT = '1;

   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] lo_cnt;
   logic [CNT_W-1:0] ph_cnt;
   logic             sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt    <= SAT;
         lo_cnt    <= '0;
         ph_cnt    <= SAT;
         sclk_prev <= 1'b1;
      end else begin
         hi_cnt    <= cs_n_o ? ((hi_cnt == SAT) ? SAT : hi_cnt + 1'b1) : '0;
         lo_cnt    <= !cs_n_o ? ((lo_cnt == SAT) ? SAT : lo_cnt + 1'b1) : '0;
         ph_cnt    <= (sclk_o != sclk_prev) ? CNT_W'(1)
                    : ((ph_cnt == SAT) ? SAT : ph_cnt + 1'b1);
         sclk_prev <= sclk_o;
      end
   end

   assert_setup_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk_o) |-> lo_cnt >= CNT_W'(SETUP_CYC));

   assert_half_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk_o) |-> ph_cnt >= CNT_W'(MIN_HALF));

   assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   assert_sclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk_o) |-> !cs_n_o);

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_valid_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $rose(cs_n_o));

   assert_quiet_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> hi_cnt >= CNT_W'(QUIET_CYC));
endmodule

bind adc_frame_ctrl afc_checker #(
   .CLK_NS      (CLK_NS),
   .SCLK_MIN_NS (SCLK_MIN_NS),
   .SETUP_NS    (SETUP_NS),
   .QUIET_NS    (QUIET_NS)
) u_afc_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n_o  (cs_n_o),
   .sclk_o  (sclk_o),
   .valid_o (valid_o)
);

// File: tb/tb_adc_frame_ctrl.sv
`timescale 1ns/1ps
module tb_adc_frame_ctrl;
   localparam int CLK_PERIOD = 5;
   localparam int SETUP_CYC  = 2;
   localparam int MINH       = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cont_i = 1'b0;
   logic [7:0]  half_div_i = 8'd5;
   logic        sdata_i = 1'b0;
   logic        cs_n_o, sclk_o, valid_o;
   logic [11:0] result_o;

   int errors = 0, checks = 0;
   int nframes = 0, nvalid = 0;
   int nfall = 0, nrise = 0, bitidx = 0, hcur = 5;
   real t_csfall = 0.0, t_csrise = 0.0, t_r13 = 0.0, t_edge = 0.0;
   bit have_rise = 0, have_r13 = 0, exact = 0, have_last = 0;
   string xtag = "R9";
   logic [15:0] word = '0;
   logic [11:0] last_res = '0;
   logic [11:0] exp_q[$];
   logic prev_cs = 1'b1, prev_valid = 1'b0;

   adc_frame_ctrl #(.CLK_NS(CLK_PERIOD)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
      .half_div_i(half_div_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o),
      .sclk_o(sclk_o), .result_o(result_o), .valid_o(valid_o));

   always #(CLK_PERIOD / 2.0) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   function automatic int heff(input int d);
      return (d < MINH) ? MINH : d;
   endfunction

   function automatic int gap_exp(input int h);
      int g = 20;
      if (60 - 7 * h > g) g = 60 - 7 * h;
      return g;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // converter model and timing monitors
   always @(negedge cs_n_o) begin
      if (rst_n) begin
         t_csfall = $realtime;
         nframes++;
         if (have_rise) begin
            chk(t_csfall - t_csrise >= gap_exp(hcur) * CLK_PERIOD, "R8",
                $sformatf("cs high %0.1f ns expected >= %0d", t_csfall - t_csrise,
                          gap_exp(hcur) * CLK_PERIOD));
            if (exact)
               chk(t_csfall - t_csrise == gap_exp(hcur) * CLK_PERIOD, xtag,
                   $sformatf("cs high %0.1f ns expected %0d", t_csfall - t_csrise,
                             gap_exp(hcur) * CLK_PERIOD));
            if (have_r13)
               chk(t_csfall - t_r13 >= 300.0, "R8",
                   $sformatf("acq %0.1f ns expected >= 300", t_csfall - t_r13));
         end
         if (have_last)
            chk(result_o == last_res, "R7",
                $sformatf("held result %h expected %h", result_o, last_res));
         hcur = heff(int'(half_div_i));
         word = 16'($urandom);
         exp_q.push_back(word[11:0]);
         bitidx = 0; nfall = 0; nrise = 0; have_r13 = 0;
      end
   end

   always @(negedge sclk_o) begin
      if (rst_n && !cs_n_o) begin
         nfall++;
         if (nfall == 1)
            chk($realtime - t_csfall == SETUP_CYC * CLK_PERIOD, "R2",
                $sformatf("setup %0.1f ns expected %0d", $realtime - t_csfall,
                          SETUP_CYC * CLK_PERIOD));
         else
            chk($realtime - t_edge == hcur * CLK_PERIOD, "R4",
                $sformatf("high phase %0.1f ns expected %0d", $realtime - t_edge,
                          hcur * CLK_PERIOD));
         t_edge = $realtime;
         if (bitidx < 16) sdata_i = word[15 - bitidx];
         bitidx++;
      end
   end

   always @(posedge sclk_o) begin
      if (rst_n && !cs_n_o) begin
         nrise++;
         chk($realtime - t_edge == hcur * CLK_PERIOD, "R4",
             $sformatf("low phase %0.1f ns expected %0d", $realtime - t_edge,
                       hcur * CLK_PERIOD));
         t_edge = $realtime;
         if (nrise == 13) begin
            t_r13 = $realtime;
            have_r13 = 1;
         end
      end
   end

   always @(posedge cs_n_o) begin
      if (rst_n) begin
         t_csrise = $realtime;
         have_rise = 1;
         chk(nfall == 16 && nrise == 16, "R3",
             $sformatf("edges fall=%0d rise=%0d expected 16/16", nfall, nrise));
         chk($realtime - t_edge == hcur * CLK_PERIOD, "R3",
             $sformatf("last high %0.1f ns expected %0d", $realtime - t_edge,
                       hcur * CLK_PERIOD));
      end
   end

   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         logic [11:0] e;
         chk(cs_n_o && !prev_cs, "R7",
             $sformatf("cs now=%b before=%b expected 1/0", cs_n_o, prev_cs));
         chk(!prev_valid, "R7", $sformatf("strobe previous=%b expected 0", prev_valid));
         chk(sclk_o, "R5", $sformatf("sclk=%b expected 1 with cs high", sclk_o));
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "strobe with no frame expected");
         end else begin
            e = exp_q.pop_front();
            chk(result_o == e, "R6", $sformatf("result %h expected %h", result_o, e));
         end
         last_res = result_o;
         have_last = 1;
         nvalid++;
      end
      prev_cs = cs_n_o;
      prev_valid = valid_o;
   end

   task automatic wait_valid(input int cnt);
      int n0 = nvalid;
      int k = 0;
      while (nvalid < n0 + cnt && k < 20000) begin
         tick(1);
         k++;
      end
      if (nvalid < n0 + cnt) chk(1'b0, "R3", "no strobe within time limit, expected one");
      tick(1);
   endtask

   task automatic run_single(input int d);
      int f0;
      half_div_i = 8'(d);
      start_i = 1'b1;
      tick(1);
      chk(cs_n_o == 1'b0, "R2", $sformatf("cs=%b expected 0 after start", cs_n_o));
      start_i = 1'b0;
      f0 = nframes;
      wait_valid(1);
      tick(120);
      chk(nframes == f0, "R10", $sformatf("frames after single %0d expected %0d", nframes, f0));
   endtask

   task automatic run_cont(input int n, input int d);
      int f0;
      half_div_i = 8'(d);
      cont_i = 1'b1;
      while (cs_n_o) tick(1);
      exact = 1; xtag = "R9";
      for (int i = 0; i < n; i++) begin
         tick(int'($urandom_range(0, 60)));
         half_div_i = 8'($urandom_range(0, 12));
         wait_valid(1);
      end
      cont_i = 1'b0;
      f0 = nframes;
      tick(100);
      exact = 0;
      chk(nframes == f0, "R9", $sformatf("frames after stop %0d expected %0d", nframes, f0));
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      #1;
      chk(cs_n_o && sclk_o && !valid_o, "R1",
          $sformatf("cs=%b sclk=%b valid=%b expected 1/1/0", cs_n_o, sclk_o, valid_o));
      tick(2);
      chk(result_o == 12'h000, "R1", $sformatf("result %h expected 000", result_o));
      exp_q.delete();
      have_rise = 0; have_r13 = 0; have_last = 0;
      rst_n = 1'b1;
      tick(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n0, f0;
      void'($urandom(32'd4711));
      tick(3);
      chk(cs_n_o && sclk_o && !valid_o && result_o == 12'h000, "R1",
          $sformatf("reset cs=%b sclk=%b valid=%b res=%h expected 1/1/0/000",
                    cs_n_o, sclk_o, valid_o, result_o));
      rst_n = 1'b1;
      tick(3);

      // directed single frames, divider clamp and acquisition-limited gaps (R4 R8)
      run_single(0);
      run_single(5);
      run_single(6);
      run_single(9);
      run_single(2);

      // requests during a frame are held once (R10)
      half_div_i = 8'd5;
      start_i = 1'b1; tick(1); start_i = 1'b0;
      exact = 1; xtag = "R10";
      f0 = nframes;
      tick(20);
      start_i = 1'b1; tick(1); start_i = 1'b0;
      tick(40);
      start_i = 1'b1; tick(1); start_i = 1'b0;
      wait_valid(2);
      tick(200);
      exact = 0;
      chk(nframes == f0 + 1, "R10", $sformatf("held frames %0d expected %0d", nframes - f0, 1));

      // divider changed mid-frame is not used until the next frame (R4)
      half_div_i = 8'd8;
      start_i = 1'b1; tick(1); start_i = 1'b0;
      tick(30);
      half_div_i = 8'd11;
      wait_valid(1);
      tick(120);

      // continuous mode (R9)
      run_cont(4, 5);
      run_cont(3, 10);

      // reset in the middle of a frame (R1)
      half_div_i = 8'd7;
      start_i = 1'b1; tick(1); start_i = 1'b0;
      tick(60);
      n0 = nvalid;
      apply_reset();
      tick(150);
      chk(nvalid == n0 && cs_n_o, "R1",
          $sformatf("strobes after abort %0d cs=%b expected 0/1", nvalid - n0, cs_n_o));

      // constrained random mix
      for (int i = 0; i < 16; i++) begin
         if ($urandom_range(0, 2) == 0) run_cont(int'($urandom_range(1, 3)),
                                                 int'($urandom_range(0, 12)));
         else run_single(int'($urandom_range(0, 12)));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule